// File: doc/BRIEF.md
# Per-Channel Zero-Run Detector

This block watches a bank of parallel audio sample streams, six by default, and reports which of them have gone silent. Each channel delivers a signed two's-complement word together with a one-cycle valid strobe. A per-channel run counter counts consecutive strobed samples whose word is exactly zero. Once a channel has seen a long enough run (1024 samples by default), its status flag goes active. A second output, the global flag, is active only while every channel qualifies at once.

All seven outputs share one polarity select. With the select at 0 an active flag reads 1. With the select at 1 an active flag reads 0. Each channel is judged only on its own strobe and data. When upstream logic copies one channel's content onto its neighbours, the neighbours' flags still follow the words they actually receive. Stereo pairing is left to the surrounding logic: ANDing the active-level forms of two channel flags gives a pair indication once both sides have run silent for the qualifying length.

Top module: `zero_run_detector`

## Requirements
- R1: A synchronous reset clears every run counter. In the cycle after reset, all channel flags and the global flag sit at the inactive level for the current polarity.
- R2: A channel flag goes active right after the clock edge that accepts the RUN_LEN-th consecutive strobed zero sample on that channel, and not before. After RUN_LEN-1 such samples it is still inactive.
- R3: A strobed nonzero sample clears that channel's run counter. The channel's flag reads inactive right after the edge that accepts the sample. A fresh run of RUN_LEN zero samples is then needed to reactivate it.
- R4: The run counter saturates at RUN_LEN and does not wrap. A flag stays active for any number of further zero samples, including runs many times RUN_LEN long.
- R5: A sample counts as zero only when all SAMPLE_W bits of its word are 0. A word with only the sign bit set (MSB, bit SAMPLE_W-1) is nonzero, and so is a word with only bit 0 set.
- R6: Each channel's flag depends only on that channel's own strobe and data. Cycles where the strobe is low neither count toward a run nor break it, whatever the data lines carry. Zero data on one channel activates only that channel, even while the other channels receive nonzero words.
- R7: The global flag is active exactly when all NUM_CH channel flags are active. It is inactive whenever at least one channel does not qualify.
- R8: The polarity select applies to all outputs without a clock edge. At 0 an active flag reads 1 and an inactive flag reads 0. At 1 an active flag reads 0 and an inactive flag reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | NUM_CH | Per-channel sample strobe; bit i belongs to channel i |
| smp_data | input | NUM_CH*SAMPLE_W | Channel i word in bits [i*SAMPLE_W +: SAMPLE_W], two's complement |
| flag_pol_low | input | 1 | Polarity select: 0 = active high, 1 = active low |
| ch_zero_flag | output | NUM_CH | Per-channel zero-run flag; bit i belongs to channel i |
| all_zero_flag | output | 1 | Global flag, active when every channel qualifies |

## Verification
The bench builds the block with six channels, 16-bit words and a run length of 8. With the short run length, the exact qualifying edge (sample 7 versus sample 8), the restart after a nonzero word, and saturation across three full run lengths can all be reached in a few dozen clocks each. A 16-bit word keeps the isolated sign bit and the isolated LSB distinct as nonzero patterns. Six channels allow the global flag to be checked with five channels qualified and one still short.

// File: rtl/zrd_pkg.sv
package zrd_pkg;

   // Output polarity encoding of the shared select bit.
   typedef enum logic {
      POL_ACT_HIGH = 1'b0,
      POL_ACT_LOW  = 1'b1
   } flag_pol_e;

   // Counter width needed to hold 0 .. run_len inclusive.
   function automatic int run_cnt_width(input int run_len);
      return $clog2(run_len + 1);
   endfunction

   // Encode an active/inactive indication at the selected polarity.
   function automatic logic encode_flag(input logic active, input flag_pol_e pol);
      return (pol == POL_ACT_LOW) ? ~active : active;
   endfunction

endpackage

// File: rtl/zrd_run_counter.sv
module zrd_run_counter #(
   parameter int SAMPLE_W = 24,
   parameter int RUN_LEN  = 1024,
   localparam int CNT_W   = zrd_pkg::run_cnt_width(RUN_LEN)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                vld,
   input  logic [SAMPLE_W-1:0] data,
   output logic                qualified
);

   localparam logic [CNT_W-1:0] TERM = CNT_W'(RUN_LEN);

   logic [CNT_W-1:0] run_q;
   logic             word_is_zero;
   logic             at_term;

   // Whole programmed word must be zero; the sign bit counts like any other.
   assign word_is_zero = ~|data;
   assign at_term      = (run_q == TERM);

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= '0;
      end else if (vld) begin
         if (!word_is_zero) begin
            run_q <= '0;
         end else if (!at_term) begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   assign qualified = at_term;

endmodule

// File: rtl/zrd_flag_encode.sv
module zrd_flag_encode #(
   parameter int NUM_CH = 6
) (
   input  logic [NUM_CH-1:0] qualified,
   input  logic              pol_low,
   output logic [NUM_CH-1:0] ch_flag,
   output logic              all_flag
);

   import zrd_pkg::*;

   flag_pol_e pol;
   logic      all_qual;

   assign pol      = flag_pol_e'(pol_low);
   assign all_qual = &qualified;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign ch_flag[i] = encode_flag(qualified[i], pol);
   end

   assign all_flag = encode_flag(all_qual, pol);

endmodule

// File: rtl/zero_run_detector.sv
module zero_run_detector #(
   parameter int NUM_CH   = 6,
   parameter int SAMPLE_W = 24,
   parameter int RUN_LEN  = 1024
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [NUM_CH-1:0]          smp_vld,
   input  logic [NUM_CH*SAMPLE_W-1:0] smp_data,
   input  logic                       flag_pol_low,
   output logic [NUM_CH-1:0]          ch_zero_flag,
   output logic                       all_zero_flag
);

   // Elaboration-time parameter checks
   if (NUM_CH < 1) begin : g_bad_ch
      initial $fatal(1, "zero_run_detector: NUM_CH must be at least 1");
   end
   if (SAMPLE_W < 2) begin : g_bad_w
      initial $fatal(1, "zero_run_detector: SAMPLE_W must be at least 2");
   end
   if (RUN_LEN < 2) begin : g_bad_len
      initial $fatal(1, "zero_run_detector: RUN_LEN must be at least 2");
   end

   logic [NUM_CH-1:0] qual;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
      zrd_run_counter #(
         .SAMPLE_W (SAMPLE_W),
         .RUN_LEN  (RUN_LEN)
      ) i_cnt (
         .clk       (clk),
         .rst       (rst),
         .vld       (smp_vld[i]),
         .data      (smp_data[i*SAMPLE_W +: SAMPLE_W]),
         .qualified (qual[i])
      );
   end

   zrd_flag_encode #(
      .NUM_CH (NUM_CH)
   ) i_enc (
      .qualified (qual),
      .pol_low   (flag_pol_low),
      .ch_flag   (ch_zero_flag),
      .all_flag  (all_zero_flag)
   );

endmodule

// File: rtl/zrd_checker.sv
module zrd_checker #(
   parameter int NUM_CH   = 6,
   parameter int SAMPLE_W = 24,
   parameter int RUN_LEN  = 1024
) (
   input logic                       clk,
   input logic                       rst,
   input logic [NUM_CH-1:0]          smp_vld,
   input logic [NUM_CH*SAMPLE_W-1:0] smp_data,
   input logic                       flag_pol_low,
   input logic [NUM_CH-1:0]          ch_zero_flag,
   input logic                       all_zero_flag
);

   localparam int MW = $clog2(RUN_LEN + 1);

   logic [NUM_CH-1:0] act;
   logic              all_act;
   logic [NUM_CH-1:0] zw;

   assign act     = ch_zero_flag ^ {NUM_CH{flag_pol_low}};
   assign all_act = all_zero_flag ^ flag_pol_low;

   AST_RESET_IDLE: assert property (@(posedge clk)
      rst |=> (act == '0) && !all_act);  // R1

   AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (rst)
      all_act == (&act));  // R7

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      logic [MW-1:0] mdl_q;

      assign zw[i] = (smp_data[i*SAMPLE_W +: SAMPLE_W] == '0);

      always_ff @(posedge clk) begin
         if (rst) begin
            mdl_q <= '0;
         end else if (smp_vld[i]) begin
            if (!zw[i]) mdl_q <= '0;
            else if (int'(mdl_q) < RUN_LEN) mdl_q <= mdl_q + 1'b1;
         end
      end

      AST_RUN_MATCH: assert property (@(posedge clk) disable iff (rst)
         act[i] == (int'(mdl_q) >= RUN_LEN));  // R4

      AST_RISE_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
         $rose(act[i]) |-> $past(smp_vld[i] && zw[i]));  // R2

      AST_NONZERO_DROPS: assert property (@(posedge clk) disable iff (rst)
         (smp_vld[i] && !zw[i]) |=> !act[i]);  // R3

      AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
         !smp_vld[i] |=> $stable(act[i]));  // R6
   end

endmodule

bind zero_run_detector zrd_checker #(
   .NUM_CH   (NUM_CH),
   .SAMPLE_W (SAMPLE_W),
   .RUN_LEN  (RUN_LEN)
) i_zrd_checker (
   .clk           (clk),
   .rst           (rst),
   .smp_vld       (smp_vld),
   .smp_data      (smp_data),
   .flag_pol_low  (flag_pol_low),
   .ch_zero_flag  (ch_zero_flag),
   .all_zero_flag (all_zero_flag)
);

// File: tb/test_zero_run_detector.sv
module test_zero_run_detector;

   localparam int NCH = 6;
   localparam int SW  = 16;
   localparam int RL  = 8;

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic [NCH-1:0]      smp_vld = '0;
   logic [NCH*SW-1:0]   smp_data = '0;
   logic                flag_pol_low = 1'b0;
   logic [NCH-1:0]      ch_zero_flag;
   logic                all_zero_flag;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   zero_run_detector #(
      .NUM_CH   (NCH),
      .SAMPLE_W (SW),
      .RUN_LEN  (RL)
   ) i_zero_run_detector (
      .clk           (clk),
      .rst           (rst),
      .smp_vld       (smp_vld),
      .smp_data      (smp_data),
      .flag_pol_low  (flag_pol_low),
      .ch_zero_flag  (ch_zero_flag),
      .all_zero_flag (all_zero_flag)
   );

   function automatic logic [NCH*SW-1:0] put(input logic [NCH*SW-1:0] v,
                                             input int ch, input logic [SW-1:0] w);
      logic [NCH*SW-1:0] r = v;
      r[ch*SW +: SW] = w;
      return r;
   endfunction

   task automatic step(input logic [NCH-1:0] v, input logic [NCH*SW-1:0] d);
      @(negedge clk);
      smp_vld  = v;
      smp_data = d;
      @(posedge clk);
      #2;
      smp_vld  = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #2;
      rst = 1'b0;
   endtask

   // exp_raw: active-level view (1 = active); converted here to port values
   task automatic chk(input logic [NCH-1:0] exp_raw, input logic exp_g, input string req);
      logic [NCH-1:0] e_ch = exp_raw ^ {NCH{flag_pol_low}};
      logic           e_g  = exp_g ^ flag_pol_low;
      vectors++;
      if (ch_zero_flag !== e_ch || all_zero_flag !== e_g) begin
         fails++;
         $display("FAIL %s: ch=%b all=%b expected ch=%b all=%b",
                  req, ch_zero_flag, all_zero_flag, e_ch, e_g);
      end
   endtask

   task automatic t_reset();
      flag_pol_low = 1'b0;
      do_reset();
      chk('0, 1'b0, "R1 reset idle high-pol");
      flag_pol_low = 1'b1;
      #1;
      chk('0, 1'b0, "R8 idle reads 1 in low-pol");
      flag_pol_low = 1'b0;
   endtask

   task automatic t_threshold();
      for (int k = 0; k < RL - 1; k++) step('1, '0);
      chk('0, 1'b0, "R2 one short of run");
      step('1, '0);
      chk('1, 1'b1, "R2 run reached, R7 all set");
   endtask

   task automatic t_saturate();
      for (int k = 0; k < 3 * RL; k++) step('1, '0);
      chk('1, 1'b1, "R4 saturated run");
   endtask

   task automatic t_nonzero();
      step('1, put('0, 2, 16'h0040));
      chk(6'h3B, 1'b0, "R3 nonzero drops ch2");
      for (int k = 0; k < RL - 1; k++) step('1, '0);
      chk(6'h3B, 1'b0, "R3 restart not yet done");
      step('1, '0);
      chk('1, 1'b1, "R3 restart complete");
   endtask

   task automatic t_zero_def();
      step('1, put(put('0, 0, 16'h8000), 1, 16'h0001));
      chk(6'h3C, 1'b0, "R5 sign bit and LSB nonzero");
   endtask

   task automatic t_global();
      do_reset();
      for (int k = 0; k < RL; k++) step(6'h1F, '0);
      chk(6'h1F, 1'b0, "R7 five of six");
      for (int k = 0; k < RL; k++) step(6'h20, '0);
      chk(6'h3F, 1'b1, "R7 all six");
   endtask

   task automatic t_strobe_gap();
      do_reset();
      for (int k = 0; k < RL; k++) begin
         step(6'h08, put({NCH{16'hFFFF}}, 3, 16'h0000));
         step(6'h00, {NCH{16'hFFFF}});
         if (k == RL - 2) chk('0, 1'b0, "R6 gaps do not count");
      end
      chk(6'h08, 1'b0, "R6 gaps do not break run");
   endtask

   task automatic t_replicate();
      logic [NCH*SW-1:0] d = {NCH{16'h1234}};
      do_reset();
      d = put(d, 0, 16'h0000);
      for (int k = 0; k < RL + 2; k++) step('1, d);
      chk(6'h01, 1'b0, "R6 own data only");
   endtask

   task automatic t_polarity();
      flag_pol_low = 1'b1;
      #1;
      chk(6'h01, 1'b0, "R8 low polarity");
      flag_pol_low = 1'b0;
      #1;
      chk(6'h01, 1'b0, "R8 back to high polarity");
   endtask

   task automatic t_midreset();
      flag_pol_low = 1'b1;
      do_reset();
      chk('0, 1'b0, "R1 reset mid-run low-pol");
      flag_pol_low = 1'b0;
      step('1, '0);
      chk('0, 1'b0, "R1 counters cleared");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_threshold();
      t_saturate();
      t_nonzero();
      t_zero_def();
      t_global();
      t_strobe_gap();
      t_replicate();
      t_polarity();
      t_midreset();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         vectors++;
         fails++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule